// File: doc/BRIEF.md
# Quad-Lane Flash Erase Sequencer

This controller sits on the host side of a serial flash device that is wired with four data lines. It runs one complete erase operation for each request it accepts. A request selects either a single-block erase at a 24-bit address or an erase of the whole device. The controller first sends a write-enable command in its own chip-select frame. It then sends the erase command. After that it reads the device status register, frame after frame, until the busy flag reads clear. When the operation ends it pulses `done`. If the busy flag is still set after a configured number of status reads, it pulses `done` together with `err`.

All bytes go out as two nibbles on the four data lines, most significant nibble first. Each nibble is presented while the serial clock is low, so the device samples stable data on the rising edge. The serial clock idles low. During a status read the controller releases the data lines after the opcode. It then clocks in two nibbles that the device drives.

The sequencer state machine has the following states:
- `S_IDLE`: accepts a request.
- `S_WREN`: write-enable frame.
- `S_ERASE`: erase frame.
- `S_POLL`: one status read per visit.
- `S_OK`: one-cycle successful completion.
- `S_FAIL`: one-cycle completion after a timeout.

Its transitions are:
- `S_IDLE`→`S_WREN` when a request is accepted.
- `S_WREN`→`S_ERASE` at the end of the write-enable frame.
- `S_ERASE`→`S_POLL` at the end of the erase frame.
- `S_POLL`→`S_POLL` when the device is busy and the read budget is not exhausted.
- `S_POLL`→`S_OK` when the busy bit reads clear.
- `S_POLL`→`S_FAIL` when the busy bit is set on the last permitted read.
- `S_OK`/`S_FAIL`→`S_IDLE` on the next cycle.

The frame engine has its own states:
- `F_IDLE`.
- `F_LEAD`: select asserted, first nibble on the bus.
- `F_SHIFT`: transmit nibbles.
- `F_READ`: receive nibbles.
- `F_GAP`: select deasserted for the inter-frame gap.

Top module: `qio_erase_ctrl`

## Requirements
- R1: Out of reset and whenever `req_ready` is high, `flash_ce_n` is 1, `flash_sck` is 0, `done` is 0 and `req_ready` is 1.
- R2: Every accepted request starts with a frame that carries only the single byte 06h.
- R3: A block erase (`req_chip`=0) sends the frame D8h, addr[23:16], addr[15:8], addr[7:0], using the address captured when the request was accepted.
- R4: A chip erase (`req_chip`=1) sends the single-byte frame C7h and no address.
- R5: Each byte is sent as two nibbles, bits [7:4] first, on `flash_sio_o[3:0]`. A nibble is driven while `flash_sck` is 0 and holds unchanged through the following high phase.
- R6: `flash_ce_n` stays high for at least 2 system clocks between any two frames.
- R7: A status read sends 05h. The controller then sets `flash_sio_oe` to 0 and clocks exactly two received nibbles, the high nibble first. Only bit 0 of the assembled byte (busy) influences the sequence; bits 7:1 are ignored.
- R8: Status reads repeat while busy reads 1. The first read with busy 0 ends the operation with a one-cycle `done` and `err`=0.
- R9: If all POLL_LIMIT status reads return busy, the operation ends with `done`=1 and `err`=1 in the same cycle, and no further frame is sent.
- R10: `req_valid` is accepted only while `req_ready` is 1. It is ignored during an operation, and `done` is never high two cycles in a row.
- R11: `flash_sck` only pulses while `flash_ce_n` is 0, and `flash_sio_oe` is 1 only while `flash_ce_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start an erase operation |
| req_chip | input | 1 | 1 = whole-device erase, 0 = block erase |
| req_addr | input | 24 | Block address for a block erase |
| req_ready | output | 1 | Controller is idle and will accept a request |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Busy never cleared; valid with `done` |
| flash_ce_n | output | 1 | Device select, active low |
| flash_sck | output | 1 | Serial clock to the device |
| flash_sio_o | output | 4 | Data lines, controller to device |
| flash_sio_oe | output | 1 | Drive enable for the data lines |
| flash_sio_i | input | 4 | Data lines, device to controller |

## Verification
The hardest case to reach from the ports is the boundary of the read budget. Busy must still read 1 on exactly the last permitted status read for the timeout to fire. A run that reads busy one time fewer must instead end in success after the same number of reads. The bench models the device. It answers each status read with a per-test count of busy responses, and it fills the upper status bits with a non-zero pattern so that a decoder which looks at the wrong bit shows up. The budget is reduced to 8 reads, and runs with 7 busy reads and with a never-clearing device sit on either side of that boundary.

// File: rtl/qio_erase_pkg.sv
package qio_erase_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WREN,
        S_ERASE,
        S_POLL,
        S_OK,
        S_FAIL
    } seq_state_t;

    typedef enum logic [2:0] {
        F_IDLE,
        F_LEAD,
        F_SHIFT,
        F_READ,
        F_GAP
    } frame_state_t;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_BLOCK = 8'hD8;
    localparam logic [7:0] OP_CHIP  = 8'hC7;
    localparam logic [7:0] OP_RDSR  = 8'h05;

endpackage

// File: rtl/qio_frame_engine.sv
module qio_frame_engine
    import qio_erase_pkg::*;
#(
    parameter int MAX_BYTES  = 4,
    parameter int GAP_CYCLES = 2,
    localparam int DW = 8 * MAX_BYTES,
    localparam int BW = $clog2(MAX_BYTES + 1),
    localparam int NW = $clog2(2 * MAX_BYTES + 1),
    localparam int GW = $clog2(GAP_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [DW-1:0] tx_data,
    input  logic [BW-1:0] tx_bytes,
    input  logic          rx_en,
    output logic          done,
    output logic [7:0]    rx_byte,
    output logic          ce_n,
    output logic          sck,
    output logic [3:0]    sio_o,
    output logic          sio_oe,
    input  logic [3:0]    sio_i
);

    frame_state_t  st;
    logic [NW-1:0] nib_left;
    logic          phase;
    logic          rx_cnt;
    logic [GW-1:0] gap_cnt;
    logic [DW-1:0] shreg;
    logic [7:0]    rx_q;
    logic          rd_q;
    logic          done_q;

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= F_IDLE;
            nib_left <= '0;
            phase    <= 1'b0;
            rx_cnt   <= 1'b0;
            gap_cnt  <= '0;
            shreg    <= '0;
            rx_q     <= '0;
            rd_q     <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st)
                F_IDLE: begin
                    if (go) begin
                        shreg    <= tx_data;
                        nib_left <= NW'({tx_bytes, 1'b0});
                        rd_q     <= rx_en;
                        phase    <= 1'b0;
                        st       <= F_LEAD;
                    end
                end
                F_LEAD: begin
                    st <= F_SHIFT;
                end
                F_SHIFT: begin
                    phase <= ~phase;
                    if (phase) begin
                        shreg    <= shreg << 4;
                        nib_left <= nib_left - 1'b1;
                        if (nib_left == NW'(1)) begin
                            if (rd_q) begin
                                st     <= F_READ;
                                rx_cnt <= 1'b0;
                            end else begin
                                st      <= F_GAP;
                                gap_cnt <= '0;
                            end
                        end
                    end
                end
                F_READ: begin
                    phase <= ~phase;
                    if (phase) begin
                        rx_q   <= {rx_q[3:0], sio_i};
                        rx_cnt <= 1'b1;
                        if (rx_cnt) begin
                            st      <= F_GAP;
                            gap_cnt <= '0;
                        end
                    end
                end
                F_GAP: begin
                    gap_cnt <= gap_cnt + 1'b1;
                    if (gap_cnt == GW'(GAP_CYCLES - 1)) begin
                        st     <= F_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: st <= F_IDLE;
            endcase
        end
    end

    // pin outputs
    always_comb begin
        ce_n    = !(st == F_LEAD || st == F_SHIFT || st == F_READ);
        sck     = phase && (st == F_SHIFT || st == F_READ);
        sio_oe  = (st == F_LEAD || st == F_SHIFT);
        sio_o   = shreg[DW-1 -: 4];
        done    = done_q;
        rx_byte = rx_q;
    end

endmodule

// File: rtl/qio_poll_budget.sv
module qio_poll_budget #(
    parameter int POLL_LIMIT = 1024,
    localparam int CW = $clog2(POLL_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic last
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (tick && cnt != CW'(POLL_LIMIT)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // the read now finishing is the final one allowed
    assign last = (cnt >= CW'(POLL_LIMIT - 1));

endmodule

// File: rtl/qio_erase_ctrl.sv
module qio_erase_ctrl
    import qio_erase_pkg::*;
#(
    parameter int POLL_LIMIT = 1024,
    parameter int GAP_CYCLES = 2,
    localparam int MAX_BYTES = 4,
    localparam int DW = 8 * MAX_BYTES,
    localparam int BW = $clog2(MAX_BYTES + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_chip,
    input  logic [23:0] req_addr,
    output logic        req_ready,
    output logic        done,
    output logic        err,
    output logic        flash_ce_n,
    output logic        flash_sck,
    output logic [3:0]  flash_sio_o,
    output logic        flash_sio_oe,
    input  logic [3:0]  flash_sio_i
);

    seq_state_t    state_q, state_d;
    logic          launch_d, go_q;
    logic          chip_q;
    logic [23:0]   addr_q;
    logic [DW-1:0] fr_data;
    logic [BW-1:0] fr_bytes;
    logic          fr_rx;
    logic          fe_done;
    logic [7:0]    fe_rx;
    logic          poll_last;
    logic          accept;

    assign accept = (state_q == S_IDLE) && req_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            go_q    <= 1'b0;
            chip_q  <= 1'b0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            go_q    <= launch_d;
            if (accept) begin
                chip_q <= req_chip;
                addr_q <= req_addr;
            end
        end
    end

    // next state
    always_comb begin
        state_d  = state_q;
        launch_d = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    state_d  = S_WREN;
                    launch_d = 1'b1;
                end
            end
            S_WREN: begin
                if (fe_done) begin
                    state_d  = S_ERASE;
                    launch_d = 1'b1;
                end
            end
            S_ERASE: begin
                if (fe_done) begin
                    state_d  = S_POLL;
                    launch_d = 1'b1;
                end
            end
            S_POLL: begin
                if (fe_done) begin
                    if (!fe_rx[0]) begin
                        state_d = S_OK;
                    end else if (poll_last) begin
                        state_d = S_FAIL;
                    end else begin
                        launch_d = 1'b1;
                    end
                end
            end
            S_OK:    state_d = S_IDLE;
            S_FAIL:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // outputs and frame contents
    always_comb begin
        req_ready = (state_q == S_IDLE);
        done      = (state_q == S_OK) || (state_q == S_FAIL);
        err       = (state_q == S_FAIL);
        fr_data   = {OP_WREN, 24'h0};
        fr_bytes  = BW'(1);
        fr_rx     = 1'b0;
        unique case (state_q)
            S_ERASE: begin
                if (chip_q) begin
                    fr_data = {OP_CHIP, 24'h0};
                end else begin
                    fr_data  = {OP_BLOCK, addr_q};
                    fr_bytes = BW'(4);
                end
            end
            S_POLL: begin
                fr_data = {OP_RDSR, 24'h0};
                fr_rx   = 1'b1;
            end
            default: ;
        endcase
    end

    qio_frame_engine #(
        .MAX_BYTES (MAX_BYTES),
        .GAP_CYCLES(GAP_CYCLES)
    ) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go_q),
        .tx_data (fr_data),
        .tx_bytes(fr_bytes),
        .rx_en   (fr_rx),
        .done    (fe_done),
        .rx_byte (fe_rx),
        .ce_n    (flash_ce_n),
        .sck     (flash_sck),
        .sio_o   (flash_sio_o),
        .sio_oe  (flash_sio_oe),
        .sio_i   (flash_sio_i)
    );

    qio_poll_budget #(
        .POLL_LIMIT(POLL_LIMIT)
    ) u_budget (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(accept),
        .tick (fe_done && state_q == S_POLL),
        .last (poll_last)
    );

endmodule

// File: rtl/qio_erase_checker.sv
module qio_erase_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       done,
    input logic       err,
    input logic       flash_ce_n,
    input logic       flash_sck,
    input logic [3:0] flash_sio_o,
    input logic       flash_sio_oe
);

    logic [1:0] hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= 2'd2;
        end else if (flash_ce_n) begin
            hi_run <= (hi_run == 2'd3) ? 2'd3 : hi_run + 2'd1;
        end else begin
            hi_run <= 2'd0;
        end
    end

    assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (flash_ce_n && !flash_sck && !done));

    assert_nibble_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_sio_oe && flash_sck) |-> $stable(flash_sio_o));

    assert_select_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flash_ce_n) |-> (hi_run >= 2'd2));

    assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_clock_framed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flash_ce_n |-> (!flash_sck && !flash_sio_oe));

endmodule

bind qio_erase_ctrl qio_erase_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .done        (done),
    .err         (err),
    .flash_ce_n  (flash_ce_n),
    .flash_sck   (flash_sck),
    .flash_sio_o (flash_sio_o),
    .flash_sio_oe(flash_sio_oe)
);

// File: tb/sim_qio_erase_ctrl.sv
module sim_qio_erase_ctrl;

    localparam int LIMIT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_chip = 1'b0;
    logic [23:0] req_addr = '0;
    logic        req_ready, done, err;
    logic        flash_ce_n, flash_sck, flash_sio_oe;
    logic [3:0]  flash_sio_o;
    logic [3:0]  sio_i_drv = 4'h0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    qio_erase_ctrl #(.POLL_LIMIT(LIMIT), .GAP_CYCLES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chip(req_chip),
        .req_addr(req_addr), .req_ready(req_ready), .done(done), .err(err),
        .flash_ce_n(flash_ce_n), .flash_sck(flash_sck), .flash_sio_o(flash_sio_o),
        .flash_sio_oe(flash_sio_oe), .flash_sio_i(sio_i_drv)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // device model and per-clock reference
    logic [3:0]  nib_q[$];
    logic [31:0] fr_word[$];
    int          fr_len[$];
    int          fr_rx[$];
    int          busy_left = 0;
    int          rx_cnt = 0;
    int          hi_cnt = 3;
    bit          prev_sck = 0, prev_ce = 1;
    bit          model_busy = 0;
    bit          model_next = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            // R10 / R1: ready tracks the model's notion of an operation in flight
            check(req_ready == !model_busy, "R10 ready", req_ready, !model_busy);
            model_next = model_busy;
            if (done) model_next = 0;
            if (req_valid && !model_busy) model_next = 1;
            model_busy = model_next;

            if (!flash_ce_n) begin
                if (prev_ce) begin
                    check(hi_cnt >= 2, "R6 gap", hi_cnt, 2);
                end
                if (flash_sck && !prev_sck) begin
                    if (flash_sio_oe) nib_q.push_back(flash_sio_o);
                    else rx_cnt++;
                end
                if (!flash_sck && !flash_sio_oe)
                    sio_i_drv <= (rx_cnt == 0) ? 4'h5 : {3'b111, busy_left > 0};
                hi_cnt = 0;
            end else begin
                hi_cnt++;
                check(!flash_sck, "R11 sck idle", flash_sck, 0);
            end
            if (flash_ce_n && !prev_ce) begin
                logic [31:0] w;
                w = '0;
                for (int k = 0; k < nib_q.size(); k++) w = {w[27:0], nib_q[k]};
                fr_word.push_back(w);
                fr_len.push_back(nib_q.size() / 2);
                fr_rx.push_back(rx_cnt);
                if (nib_q.size() == 2 && w[7:0] == 8'h05 && busy_left > 0) busy_left--;
                nib_q.delete();
                rx_cnt = 0;
            end
            prev_sck = flash_sck;
            prev_ce  = flash_ce_n;
        end
    end

    task automatic run_op(input bit chip, input logic [23:0] addr, input int busy_n,
                          input bit exp_err, input bit poke);
        int n_polls;
        int waited;
        int nf;
        fr_word.delete(); fr_len.delete(); fr_rx.delete();
        busy_left = busy_n;
        @(posedge clk); #2;
        req_valid = 1; req_chip = chip; req_addr = addr;
        @(posedge clk); #2;
        req_valid = 0; req_addr = 24'hABCDEF; req_chip = !chip;
        if (poke) begin
            repeat (20) @(posedge clk);
            #2 req_valid = 1;
            @(posedge clk); #2 req_valid = 0;
        end
        waited = 0;
        while (waited < 5000) begin
            @(negedge clk);
            if (done) break;
            waited++;
        end
        check(done == 1, "R8 done seen", done, 1);
        check(err == exp_err, exp_err ? "R9 err" : "R8 no err", err, exp_err);
        @(negedge clk);
        check(done == 0, "R10 done single", done, 0);
        repeat (40) @(negedge clk);
        n_polls = exp_err ? LIMIT : busy_n + 1;
        nf = fr_word.size();
        check(nf == n_polls + 2, "R9 frame count", nf, n_polls + 2);
        if (nf >= 2) begin
            check(fr_len[0] == 1 && fr_word[0] == 32'h06, "R2 wren frame", fr_word[0], 32'h06);
            if (chip)
                check(fr_len[1] == 1 && fr_word[1] == 32'hC7, "R4 chip frame", fr_word[1], 32'hC7);
            else
                check(fr_len[1] == 4 && fr_word[1] == {8'hD8, addr}, "R3 R5 block frame",
                      fr_word[1], {8'hD8, addr});
            for (int k = 2; k < nf; k++) begin
                check(fr_len[k] == 1 && fr_word[k] == 32'h05, "R7 poll opcode", fr_word[k], 32'h05);
                check(fr_rx[k] == 2, "R7 read nibbles", fr_rx[k], 2);
            end
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        check(flash_ce_n == 1 && flash_sck == 0, "R1 reset pins", {flash_ce_n, flash_sck}, 2'b10);
        check(req_ready == 1 && done == 0, "R1 reset status", {req_ready, done}, 2'b10);
        run_op(0, 24'h123456, 3, 0, 0);          // R3 block erase, R8 short busy
        run_op(1, 24'h000000, 0, 0, 0);          // R4 chip erase, immediately idle
        run_op(0, 24'hFFFFFF, 100, 1, 0);        // R9 never clears
        run_op(1, 24'h000000, LIMIT - 1, 0, 0);  // R8 clears on the last read
        run_op(0, 24'h0A5A5A, 2, 0, 1);          // R10 request during operation ignored
        check(flash_ce_n == 1 && req_ready == 1, "R10 quiet after op", flash_ce_n, 1);
        finish_run();
    end

endmodule